// File: doc/BRIEF.md
# Multiplier-Free Radix-2 Butterfly with Pipelined Vector Rotation

This block computes one radix-2 decimation-in-frequency butterfly per clock. It takes two complex samples `p` and `q` and a twiddle angle. The upper output carries the complex sum `p + q`. The lower output carries the difference `p - q` turned by the twiddle angle. The turn is done by an unrolled chain of shift-and-add micro-rotations, so the block contains no general multiplier. Every real and imaginary part is a 16-bit two's-complement word.

The angle is an unsigned binary fraction of one full turn. The rotation is counterclockwise, so a caller that wants the forward-transform twiddle `e^(-j2πk/N)` passes the two's complement of `k·2^16/N`. An angle that the micro-rotation chain cannot reach is first brought into range by an exact quarter-turn swap. The gain that the chain adds is removed once, in a single scaling step at the end. A valid flag travels with each operand set. The block accepts a new operand set on every clock and returns each result after a fixed number of cycles.

Top module: `cordic_bfly`

## Requirements
- R1: For each accepted operand set, `sumRe` = `pRe + qRe` and `sumIm` = `pIm + qIm`. Each result is saturated to the range -32768..32767.
- R2: For each accepted operand set, let `dRe` = `pRe - qRe`, `dIm` = `pIm - qIm` and θ = 2π·`angle`/65536. Before saturation, `rotRe` is within ±10 of `dRe·cosθ - dIm·sinθ` and `rotIm` is within ±10 of `dRe·sinθ + dIm·cosθ`. This is a counterclockwise turn.
- R3: When the ideal rotated value lies outside -32768..32767, `rotRe` and `rotIm` saturate to the nearest limit, still within the ±10 tolerance of that clipped value.
- R4: The top two angle bits select the quadrant. Code 01 (90° up to 180°) is pre-turned by +90°. Code 10 (180° up to 270°) is pre-turned by -90°. Codes 00 and 11 are not pre-turned. The angle left for the micro-rotation chain never exceeds a quarter turn. R2 holds at every quadrant edge, including angles 0x3FFF, 0x4000, 0x7FFF, 0x8000, 0xBFFF, 0xC000 and 0xFFFF.
- R5: Operands sampled with `inValid` high at rising edge n produce `outValid` high, with their results, after rising edge n+17. Back-to-back operand sets give back-to-back results in the same order.
- R6: Inputs sampled with `inValid` low produce no result. While `outValid` is low, all four result outputs keep their previous values.
- R7: While `rstN` is low, `outValid` and all result outputs are zero.
- R8: For every valid operand set, the angle still left after the last of the 16 micro-rotations is no larger than the last step angle plus the rounding of the stored step constants.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Operand set on the inputs is to be processed |
| pRe | input | 16 | Upper sample, real part |
| pIm | input | 16 | Upper sample, imaginary part |
| qRe | input | 16 | Lower sample, real part |
| qIm | input | 16 | Lower sample, imaginary part |
| angle | input | 16 | Twiddle angle as an unsigned fraction of a full turn |
| outValid | output | 1 | Result outputs carry a new butterfly result |
| sumRe | output | 16 | Saturated real part of p + q |
| sumIm | output | 16 | Saturated imaginary part of p + q |
| rotRe | output | 16 | Real part of the rotated difference |
| rotIm | output | 16 | Imaginary part of the rotated difference |

## Verification
The hardest cases to reach from the ports are angles one code on either side of a quadrant edge. At these points the pre-turn switches direction and the leftover angle sits at the very edge of the micro-rotation range. The bench drives every such code with differences of several sizes and signs. It also drives full-scale differences, at zero angle and at 45°, that push the rotated value past the 16-bit limit, together with sums that overflow. Long runs of back-to-back random operand sets are mixed with idle gaps, during which garbage sits on the inputs, to test ordering, fixed latency and output holding against a queue-based model.

// File: rtl/cbfly_pkg.sv
package cbfly_pkg;

  // Number of micro-rotation steps in the unrolled chain.
  localparam int unsigned ROT_STAGES = 16;
  // Entry register + rotation steps + gain/round/saturate register.
  localparam int unsigned PIPE_DEPTH = ROT_STAGES + 2;

  // Per-level load enables handed from the control to the datapath.
  typedef struct packed {
    logic [PIPE_DEPTH-1:0] load;
  } pipeStrobe_t;

  function automatic real pow2Neg(input int n);
    real r;
    r = 1.0;
    for (int k = 0; k < n; k++) r = r / 2.0;
    return r;
  endfunction

  function automatic real pow2Pos(input int n);
    real r;
    r = 1.0;
    for (int k = 0; k < n; k++) r = r * 2.0;
    return r;
  endfunction

  // arctan(2^-i) in radians, evaluated at elaboration time.
  function automatic real arctanStep(input int i);
    real x;
    real term;
    real acc;
    if (i == 0) return 0.78539816339744831;
    x = pow2Neg(i);
    term = x;
    acc = 0.0;
    for (int k = 0; k < 40; k++) begin
      acc = acc + (((k % 2) == 1) ? -1.0 : 1.0) * term / real'(2 * k + 1);
      term = term * x * x;
    end
    return acc;
  endfunction

  // Step angle in units of one turn / 2^fracBits, rounded.
  function automatic int atanUnits(input int i, input int fracBits);
    real turns;
    turns = arctanStep(i) / 6.283185307179586;
    return $rtoi(turns * pow2Pos(fracBits) + 0.5);
  endfunction

  function automatic real sqrtIter(input real v);
    real g;
    g = v;
    for (int k = 0; k < 40; k++) g = 0.5 * (g + v / g);
    return g;
  endfunction

  // Inverse aggregate gain of n micro-rotations, scaled by 2^kb.
  function automatic int kUnits(input int n, input int kb);
    real prod;
    prod = 1.0;
    for (int i = 0; i < n; i++) prod = prod / sqrtIter(1.0 + pow2Neg(2 * i));
    return $rtoi(prod * pow2Pos(kb) + 0.5);
  endfunction

endpackage

// File: rtl/bfly_ctrl.sv
module bfly_ctrl
  import cbfly_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  output pipeStrobe_t strobe,
  output logic        outValid
);

  logic [PIPE_DEPTH-1:0] vldPipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) vldPipe <= '0;
    else       vldPipe <= {vldPipe[PIPE_DEPTH-2:0], inValid};
  end

  // Level k loads when the data feeding it is valid.
  always_comb strobe.load = {vldPipe[PIPE_DEPTH-2:0], inValid};

  assign outValid = vldPipe[PIPE_DEPTH-1];

endmodule

// File: rtl/cordic_stage.sv
module cordic_stage #(
  parameter int IW    = 22,
  parameter int ZW    = 23,
  parameter int SHIFT = 0,
  parameter logic signed [ZW-1:0] STEP = '0
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 load,
  input  logic signed [IW-1:0] xIn,
  input  logic signed [IW-1:0] yIn,
  input  logic signed [ZW-1:0] zIn,
  output logic signed [IW-1:0] xOut,
  output logic signed [IW-1:0] yOut,
  output logic signed [ZW-1:0] zOut
);

  logic signed [IW-1:0] xSh, ySh;
  logic                 turnNeg;

  always_comb begin
    xSh     = xIn >>> SHIFT;
    ySh     = yIn >>> SHIFT;
    turnNeg = zIn[ZW-1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      xOut <= '0;
      yOut <= '0;
      zOut <= '0;
    end else if (load) begin
      if (turnNeg) begin
        xOut <= xIn + ySh;
        yOut <= yIn - xSh;
        zOut <= zIn + STEP;
      end else begin
        xOut <= xIn - ySh;
        yOut <= yIn + xSh;
        zOut <= zIn - STEP;
      end
    end
  end

endmodule

// File: rtl/bfly_datapath.sv
module bfly_datapath
  import cbfly_pkg::*;
#(
  parameter int DW     = 16,
  parameter int AW     = 16,
  parameter int FRAC   = 3,
  parameter int ZGUARD = 6,
  parameter int KB     = 18
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  pipeStrobe_t          strobe,
  input  logic signed [DW-1:0] pRe,
  input  logic signed [DW-1:0] pIm,
  input  logic signed [DW-1:0] qRe,
  input  logic signed [DW-1:0] qIm,
  input  logic        [AW-1:0] angle,
  output logic signed [DW-1:0] sumRe,
  output logic signed [DW-1:0] sumIm,
  output logic signed [DW-1:0] rotRe,
  output logic signed [DW-1:0] rotIm
);

  localparam int NS  = ROT_STAGES;
  localparam int LAT = PIPE_DEPTH;
  localparam int IW  = DW + 3 + FRAC;
  localparam int ZF  = AW + ZGUARD;
  localparam int ZW  = ZF + 1;
  localparam int PW  = IW + KB + 1;
  localparam int RSH = FRAC + KB;

  localparam logic signed [ZW-1:0] QUARTER = ZW'(1) <<< (ZF - 2);
  localparam logic        [KB-1:0] KCONST  = KB'(kUnits(NS, KB));
  localparam logic signed [PW-1:0] HALF    = PW'(1) <<< (RSH - 1);
  localparam logic signed [PW-1:0] HI      = {{(PW-DW+1){1'b0}}, {(DW-1){1'b1}}};
  localparam logic signed [PW-1:0] LO      = {{(PW-DW+1){1'b1}}, {(DW-1){1'b0}}};
  localparam logic signed [ZW-1:0] ZBOUND  = ZW'(atanUnits(NS - 1, ZF) + NS);

  function automatic logic signed [DW-1:0] clampDw(input logic signed [PW-1:0] v);
    if (v > HI)      return HI[DW-1:0];
    else if (v < LO) return LO[DW-1:0];
    else             return v[DW-1:0];
  endfunction

  // Gain correction as a sum of shifted copies, one per set constant bit.
  function automatic logic signed [PW-1:0] scaleK(input logic signed [IW-1:0] v);
    logic signed [PW-1:0] ve;
    logic signed [PW-1:0] acc;
    ve  = {{(PW-IW){v[IW-1]}}, v};
    acc = '0;
    for (int b = 0; b < KB; b++) begin
      if (KCONST[b]) acc = acc + (ve <<< b);
    end
    return acc;
  endfunction

  // ---------------- entry level: difference, sum, quarter pre-turn -------
  logic signed [DW:0]   dRe, dIm, addRe, addIm;
  logic signed [IW-1:0] xs, ys, x0, y0;
  logic signed [ZW-1:0] zs, z0;

  always_comb begin
    dRe   = {pRe[DW-1], pRe} - {qRe[DW-1], qRe};
    dIm   = {pIm[DW-1], pIm} - {qIm[DW-1], qIm};
    addRe = {pRe[DW-1], pRe} + {qRe[DW-1], qRe};
    addIm = {pIm[DW-1], pIm} + {qIm[DW-1], qIm};
    xs    = {{(IW-DW-1-FRAC){dRe[DW]}}, dRe, {FRAC{1'b0}}};
    ys    = {{(IW-DW-1-FRAC){dIm[DW]}}, dIm, {FRAC{1'b0}}};
    zs    = {angle[AW-1], angle, {ZGUARD{1'b0}}};
    unique case (angle[AW-1:AW-2])
      2'b01: begin x0 = -ys; y0 = xs;  z0 = zs - QUARTER; end
      2'b10: begin x0 = ys;  y0 = -xs; z0 = zs + QUARTER; end
      default: begin x0 = xs; y0 = ys; z0 = zs; end
    endcase
  end

  logic signed [IW-1:0] xr [NS+1];
  logic signed [IW-1:0] yr [NS+1];
  logic signed [ZW-1:0] zr [NS+1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      xr[0] <= '0;
      yr[0] <= '0;
      zr[0] <= '0;
    end else if (strobe.load[0]) begin
      xr[0] <= x0;
      yr[0] <= y0;
      zr[0] <= z0;
    end
  end

  // ---------------- micro-rotation chain ---------------------------------
  for (genvar i = 0; i < NS; i++) begin : g_rot
    cordic_stage #(
      .IW   (IW),
      .ZW   (ZW),
      .SHIFT(i),
      .STEP (ZW'(atanUnits(i, ZF)))
    ) u_stage (
      .clk (clk),
      .rstN(rstN),
      .load(strobe.load[i+1]),
      .xIn (xr[i]),
      .yIn (yr[i]),
      .zIn (zr[i]),
      .xOut(xr[i+1]),
      .yOut(yr[i+1]),
      .zOut(zr[i+1])
    );
  end

  // ---------------- gain, round, saturate --------------------------------
  logic signed [PW-1:0] kRe, kIm;

  always_comb begin
    kRe = (scaleK(xr[NS]) + HALF) >>> RSH;
    kIm = (scaleK(yr[NS]) + HALF) >>> RSH;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rotRe <= '0;
      rotIm <= '0;
    end else if (strobe.load[LAT-1]) begin
      rotRe <= clampDw(kRe);
      rotIm <= clampDw(kIm);
    end
  end

  // ---------------- sum path delay line ----------------------------------
  logic signed [DW-1:0] sRe [LAT];
  logic signed [DW-1:0] sIm [LAT];

  for (genvar k = 0; k < LAT; k++) begin : g_sum
    if (k == 0) begin : g_head
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sRe[0] <= '0;
          sIm[0] <= '0;
        end else if (strobe.load[0]) begin
          sRe[0] <= clampDw({{(PW-DW-1){addRe[DW]}}, addRe});
          sIm[0] <= clampDw({{(PW-DW-1){addIm[DW]}}, addIm});
        end
      end
    end else begin : g_tail
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sRe[k] <= '0;
          sIm[k] <= '0;
        end else if (strobe.load[k]) begin
          sRe[k] <= sRe[k-1];
          sIm[k] <= sIm[k-1];
        end
      end
    end
  end

  assign sumRe = sRe[LAT-1];
  assign sumIm = sIm[LAT-1];

  // ---------------- checks -----------------------------------------------
  logic signed [ZW-1:0] absZ0, absZn;
  always_comb begin
    absZ0 = zr[0][ZW-1]  ? -zr[0]  : zr[0];
    absZn = zr[NS][ZW-1] ? -zr[NS] : zr[NS];
  end

  // R4
  prerot_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load[1] |-> (absZ0 <= QUARTER));

  // R8
  residual_conv_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load[LAT-1] |-> (absZn <= ZBOUND));

endmodule

// File: rtl/cordic_bfly.sv
module cordic_bfly
  import cbfly_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 inValid,
  input  logic signed [DW-1:0] pRe,
  input  logic signed [DW-1:0] pIm,
  input  logic signed [DW-1:0] qRe,
  input  logic signed [DW-1:0] qIm,
  input  logic        [AW-1:0] angle,
  output logic                 outValid,
  output logic signed [DW-1:0] sumRe,
  output logic signed [DW-1:0] sumIm,
  output logic signed [DW-1:0] rotRe,
  output logic signed [DW-1:0] rotIm
);

  localparam int CW = $clog2(PIPE_DEPTH + 1);

  pipeStrobe_t strobe;

  bfly_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .strobe  (strobe),
    .outValid(outValid)
  );

  bfly_datapath #(
    .DW(DW),
    .AW(AW)
  ) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .strobe(strobe),
    .pRe   (pRe),
    .pIm   (pIm),
    .qRe   (qRe),
    .qIm   (qIm),
    .angle (angle),
    .sumRe (sumRe),
    .sumIm (sumIm),
    .rotRe (rotRe),
    .rotIm (rotIm)
  );

  // Edges seen since reset release, saturating; guards the latency check.
  logic [CW-1:0] sinceRst;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                           sinceRst <= '0;
    else if (sinceRst != CW'(PIPE_DEPTH)) sinceRst <= sinceRst + 1'b1;
  end

  // R5
  fixed_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst == CW'(PIPE_DEPTH)) |-> (outValid == $past(inValid, PIPE_DEPTH)));

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> ($stable(sumRe) && $stable(sumIm) && $stable(rotRe) && $stable(rotIm)));

endmodule

// File: tb/sim_cordic_bfly.sv
`timescale 1ns/1ps
module sim_cordic_bfly;

  localparam int  LATE  = 18;
  localparam int  TOL   = 10;
  localparam real TWOPI = 6.283185307179586;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic signed [15:0] pRe = '0, pIm = '0, qRe = '0, qIm = '0;
  logic [15:0] angle = '0;
  logic outValid;
  logic signed [15:0] sumRe, sumIm, rotRe, rotIm;

  always #2.5 clk = ~clk;

  cordic_bfly u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid),
    .pRe(pRe), .pIm(pIm), .qRe(qRe), .qIm(qIm), .angle(angle),
    .outValid(outValid), .sumRe(sumRe), .sumIm(sumIm),
    .rotRe(rotRe), .rotIm(rotIm)
  );

  typedef struct {
    int  due;
    int  eSumRe;
    int  eSumIm;
    real eRotRe;
    real eRotIm;
    bit  satRe;
    bit  satIm;
  } expect_t;

  expect_t pend[$];
  int  cyc = 0;
  int  tests = 0;
  int  fails = 0;
  bit  done = 1'b0;
  bit  haveLast = 1'b0;
  int  lastSR, lastSI, lastRR, lastRI;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int clampI(input int v);
    if (v > 32767)  return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  function automatic real clampR(input real v);
    if (v > 32767.0)  return 32767.0;
    if (v < -32768.0) return -32768.0;
    return v;
  endfunction

  function automatic real absR(input real v);
    return (v < 0.0) ? -v : v;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input real act, input real exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0.2f expected=%0.2f (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  // Drive one operand set; the model entry is queued with its due cycle.
  task automatic send(input int pr, input int pi, input int qr, input int qi, input int ang);
    expect_t e;
    real th, dr, di, xr, yr;
    @(negedge clk);
    pRe = 16'(pr); pIm = 16'(pi); qRe = 16'(qr); qIm = 16'(qi);
    angle = 16'(ang); inValid = 1'b1;
    th = TWOPI * real'(ang & 16'hFFFF) / 65536.0;
    dr = real'($signed(pRe)) - real'($signed(qRe));
    di = real'($signed(pIm)) - real'($signed(qIm));
    xr = dr * $cos(th) - di * $sin(th);
    yr = dr * $sin(th) + di * $cos(th);
    e.due    = cyc + LATE;
    e.eSumRe = clampI(int'($signed(pRe)) + int'($signed(qRe)));
    e.eSumIm = clampI(int'($signed(pIm)) + int'($signed(qIm)));
    e.eRotRe = clampR(xr);
    e.eRotIm = clampR(yr);
    e.satRe  = (absR(xr) > 32767.0);
    e.satIm  = (absR(yr) > 32767.0);
    pend.push_back(e);
  endtask

  // Idle cycles with garbage on the data inputs (R6).
  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      inValid = 1'b0;
      pRe = 16'($urandom); pIm = 16'($urandom);
      qRe = 16'($urandom); qIm = 16'($urandom);
      angle = 16'($urandom);
    end
  endtask

  // Output monitor, sampling away from the rising edge.
  always @(negedge clk) begin
    if (rstN && !done) begin
      if (outValid) begin
        if (pend.size() == 0) begin
          check(1'b0, "R6", "outValid with nothing pending", 1.0, 0.0);
        end else begin
          expect_t e;
          e = pend.pop_front();
          check(e.due == cyc, "R5", "result cycle", real'(cyc), real'(e.due));
          check(int'(sumRe) == e.eSumRe, "R1", "sumRe", real'(sumRe), real'(e.eSumRe));
          check(int'(sumIm) == e.eSumIm, "R1", "sumIm", real'(sumIm), real'(e.eSumIm));
          check(absR(real'(rotRe) - e.eRotRe) <= real'(TOL), e.satRe ? "R3" : "R2",
                "rotRe", real'(rotRe), e.eRotRe);
          check(absR(real'(rotIm) - e.eRotIm) <= real'(TOL), e.satIm ? "R3" : "R2",
                "rotIm", real'(rotIm), e.eRotIm);
        end
      end else begin
        if (pend.size() != 0 && pend[0].due <= cyc)
          check(1'b0, "R5", "missing result", 0.0, real'(pend[0].due));
        if (haveLast)
          check(int'(sumRe) == lastSR && int'(sumIm) == lastSI &&
                int'(rotRe) == lastRR && int'(rotIm) == lastRI,
                "R6", "outputs changed while idle", real'(rotRe), real'(lastRR));
      end
      haveLast = 1'b1;
      lastSR = sumRe; lastSI = sumIm; lastRR = rotRe; lastRI = rotIm;
    end
  end

  // Watchdog.
  initial begin
    #(5ns * 200000);
    if (!done) begin
      done = 1'b1;
      fails++;
      tests++;
      $display("FAIL watchdog expired actual=%0d expected=finish", cyc);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int edges[$];
    // R7: reset state
    repeat (3) @(negedge clk);
    check(outValid == 1'b0, "R7", "outValid in reset", real'(outValid), 0.0);
    check(sumRe == 0 && sumIm == 0, "R7", "sum in reset", real'(sumRe), 0.0);
    check(rotRe == 0 && rotIm == 0, "R7", "rot in reset", real'(rotRe), 0.0);
    rstN = 1'b1;
    idle(3);

    // R2: basic angles on a small vector
    send(1000, 0, 0, 0, 16'h0000);
    send(1000, 0, 0, 0, 16'h2000);
    send(1000, 0, 0, 0, 16'h1555);
    send(0, 700, 0, -300, 16'hE000);
    idle(2);

    // R4: every quadrant edge, several differences
    edges = '{16'h0000, 16'h0001, 16'h3FFF, 16'h4000, 16'h4001, 16'h7FFF, 16'h8000,
              16'h8001, 16'hBFFF, 16'hC000, 16'hC001, 16'hFFFF, 16'h6000, 16'hA000};
    foreach (edges[k]) begin
      send(12000, -5000, -3000, 4000, edges[k]);
      send(-20000, 15000, 5000, -6000, edges[k]);
      send(7, -9, 0, 0, edges[k]);
    end
    idle(5);

    // R1/R3: saturation of sum and of rotated difference
    send(32767, -32768, 1, -1, 16'h0000);
    send(32767, 32767, -32768, -32768, 16'h0000);
    send(32767, 32767, -32768, -32768, 16'h2000);
    send(-32768, 32767, 32767, -32768, 16'h6000);
    send(32767, 0, -32768, 0, 16'h8000);
    send(20000, 20000, -20000, -20000, 16'h1000);
    idle(4);

    // R5/R6: random back-to-back bursts with idle gaps
    for (int b = 0; b < 20; b++) begin
      for (int k = 0; k < 25; k++)
        send($urandom_range(0, 65535) - 32768, $urandom_range(0, 65535) - 32768,
             $urandom_range(0, 65535) - 32768, $urandom_range(0, 65535) - 32768,
             $urandom_range(0, 65535));
      idle(b % 4);
    end

    idle(LATE + 6);
    check(pend.size() == 0, "R5", "results left pending", real'(pend.size()), 0.0);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule